// File: doc/BRIEF.md
# Paired-Slot Instruction Dispatcher

This block accepts a 64-bit instruction word, together with the address it was fetched from. It decides how the two 32-bit halves of the word reach a memory-side execution unit and an integer-side execution unit. Two format bits in the word select one of four issue styles:

- both halves issued together, one to each unit;
- the upper half first, then the lower half;
- the lower half first, then the upper half;
- the whole word issued as a single long instruction.

The dispatcher issues each sub-instruction as a one-cycle strobe and waits for the addressed unit to acknowledge. Each acknowledgement carries a branch-taken flag, a branch target and a kill-right flag. The dispatcher pulses a write-back commit strobe at the points where results become architecturally visible. When the word is finished, it produces a single next-PC decision.

In the two sequential styles, the second sub-instruction is dropped when the first one branches or asks for its partner to be cancelled. In the parallel style the two branch results are merged. If both units branch, that is a fault: a sticky error flag is raised and no jump is reported. A host pipeline pulses `start` while `busy` is low and consumes the `done` pulse.

Top module: `pairword_dispatch`

## Requirements
- R1: The issue style is {word[63], word[31]} read as a 2-bit number: 0 parallel, 1 upper-then-lower, 2 lower-then-upper, 3 long. `mem_bits` always shows word[63:32] and `int_bits` shows word[31:0] of the word being dispatched.
- R2: In long style, one issue is made as a `mem_issue` pulse with `iss_long` high and `int_issue` low. After the memory acknowledgement there is one commit, and the next PC follows the memory unit's branch result.
- R3: In upper-then-lower style, the first issue is a `mem_issue` pulse. A second issue, if made, is an `int_issue` pulse.
- R4: In lower-then-upper style, the first issue is an `int_issue` pulse. A second issue, if made, is a `mem_issue` pulse.
- R5: In both sequential styles, the second issue is not made when the first acknowledgement reports a taken branch or kill-right. A taken branch gives `jump`=1 with `npc` equal to that target, and a branch wins over kill.
- R6: In sequential styles, `commit` pulses once per acknowledged sub-instruction. In parallel and long styles it pulses once per word, in the same cycle as `done`.
- R7: In parallel style, `mem_issue` and `int_issue` pulse in the same cycle. `done` waits for both acknowledgements, whatever their order. If exactly one unit reports a branch, `npc` is its target and `jump`=1.
- R8: When no branch decides the next PC, `npc` is the start address plus 8 and `jump`=0. This covers no branch in any style, and a kill with no branch in sequential styles.
- R9: A parallel word in which both units branch sets `err`, reports `jump`=0 and `npc` equal to the start address plus 8. `err` then stays high until reset.
- R10: `start` pulses while `busy` is high are ignored. Kill-right is ignored in parallel and long styles and on the second sequential sub-instruction.
- R11: After reset, `busy`, `err`, `done`, `commit` and both issue strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin dispatching `word` (taken when idle) |
| word | input | 64 | Instruction word |
| pc | input | AW | Address of the word |
| busy | output | 1 | A word is being dispatched |
| mem_issue | output | 1 | Issue strobe to the memory unit |
| int_issue | output | 1 | Issue strobe to the integer unit |
| iss_long | output | 1 | Current memory issue is a long instruction |
| mem_bits | output | 32 | Upper half of the word |
| int_bits | output | 32 | Lower half of the word |
| mem_ack | input | 1 | Memory unit finished its sub-instruction |
| mem_br | input | 1 | Memory unit branch taken |
| mem_tgt | input | AW | Memory unit branch target |
| mem_kill | input | 1 | Memory unit asks to cancel the second issue |
| int_ack | input | 1 | Integer unit finished its sub-instruction |
| int_br | input | 1 | Integer unit branch taken |
| int_tgt | input | AW | Integer unit branch target |
| int_kill | input | 1 | Integer unit asks to cancel the second issue |
| commit | output | 1 | Write-back commit strobe |
| done | output | 1 | Next-PC decision valid (one cycle) |
| jump | output | 1 | `npc` is a branch target |
| npc | output | AW | Next PC |
| err | output | 1 | Sticky dual-branch fault |

## Verification
The assertions check these properties on every cycle:
- a long issue never strobes the integer unit;
- issue strobes appear only while busy;
- commits appear only while busy or together with `done`;
- the first rise of the fault flag coincides with a no-jump result;
- the fault flag, once set, never falls.

Issue order, suppression of the second issue, branch merging and the fall-through address depend on what the units answer and when. Only the bench scenarios can show these, using stub units with varied acknowledgement latencies, random branch and kill answers, and directed cases for dual branch and `start` pulses while busy.

// File: rtl/pairword_dispatch.sv
module pairword_dispatch #(
  parameter int AW   = 32,
  parameter int HW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2*HW-1:0] word,
  input  logic [AW-1:0] pc,
  output logic          busy,
  output logic          mem_issue,
  output logic          int_issue,
  output logic          iss_long,
  output logic [HW-1:0] mem_bits,
  output logic [HW-1:0] int_bits,
  input  logic          mem_ack,
  input  logic          mem_br,
  input  logic [AW-1:0] mem_tgt,
  input  logic          mem_kill,
  input  logic          int_ack,
  input  logic          int_br,
  input  logic [AW-1:0] int_tgt,
  input  logic          int_kill,
  output logic          commit,
  output logic          done,
  output logic          jump,
  output logic [AW-1:0] npc,
  output logic          err
);
  localparam int WW = 2 * HW;
  localparam logic [1:0] F_PAR = 2'd0, F_LR = 2'd1, F_RL = 2'd2, F_LONG = 2'd3;
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;

  st_t           st;
  logic [1:0]    fmt;
  logic [WW-1:0] wq;
  logic [AW-1:0] pc_q;
  logic          got_m, got_i, m_br, i_br;
  logic [AW-1:0] m_tgt, i_tgt;

  wire [AW-1:0] fall   = pc_q + AW'(STEP);
  wire          rl     = (fmt == F_RL);
  wire          a1     = rl ? int_ack  : mem_ack;
  wire          b1     = rl ? int_br   : mem_br;
  wire [AW-1:0] t1     = rl ? int_tgt  : mem_tgt;
  wire          k1     = rl ? int_kill : mem_kill;
  wire          a2     = rl ? mem_ack  : int_ack;
  wire          b2     = rl ? mem_br   : int_br;
  wire [AW-1:0] t2     = rl ? mem_tgt  : int_tgt;
  wire          m_have = got_m | mem_ack;
  wire          i_have = got_i | int_ack;
  wire          mb     = got_m ? m_br  : mem_br;
  wire          ib     = got_i ? i_br  : int_br;
  wire [AW-1:0] mt     = got_m ? m_tgt : mem_tgt;
  wire [AW-1:0] it     = got_i ? i_tgt : int_tgt;

  assign busy     = (st != S_IDLE);
  assign mem_bits = wq[WW-1:HW];
  assign int_bits = wq[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fmt <= F_PAR; wq <= '0; pc_q <= '0;
      got_m <= 1'b0; got_i <= 1'b0; m_br <= 1'b0; i_br <= 1'b0;
      m_tgt <= '0; i_tgt <= '0;
      mem_issue <= 1'b0; int_issue <= 1'b0; iss_long <= 1'b0;
      commit <= 1'b0; done <= 1'b0; jump <= 1'b0; npc <= '0; err <= 1'b0;
    end else begin
      mem_issue <= 1'b0; int_issue <= 1'b0; iss_long <= 1'b0;
      commit <= 1'b0; done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fmt   <= {word[WW-1], word[HW-1]};
          wq    <= word;
          pc_q  <= pc;
          got_m <= 1'b0; got_i <= 1'b0;
          st    <= S_FIRST;
          unique case ({word[WW-1], word[HW-1]})
            F_PAR:  begin mem_issue <= 1'b1; int_issue <= 1'b1; end
            F_LR:   mem_issue <= 1'b1;
            F_RL:   int_issue <= 1'b1;
            F_LONG: begin mem_issue <= 1'b1; iss_long <= 1'b1; end
          endcase
        end
        S_FIRST: begin
          if (fmt == F_PAR) begin
            if (m_have && i_have) begin
              commit <= 1'b1; done <= 1'b1; st <= S_IDLE;
              if (mb && ib) begin
                err <= 1'b1; jump <= 1'b0; npc <= fall;
              end else if (mb) begin
                jump <= 1'b1; npc <= mt;
              end else if (ib) begin
                jump <= 1'b1; npc <= it;
              end else begin
                jump <= 1'b0; npc <= fall;
              end
            end else begin
              if (mem_ack) begin got_m <= 1'b1; m_br <= mem_br; m_tgt <= mem_tgt; end
              if (int_ack) begin got_i <= 1'b1; i_br <= int_br; i_tgt <= int_tgt; end
            end
          end else if (fmt == F_LONG) begin
            if (mem_ack) begin
              commit <= 1'b1; done <= 1'b1; st <= S_IDLE;
              jump <= mem_br; npc <= mem_br ? mem_tgt : fall;
            end
          end else if (a1) begin
            commit <= 1'b1;
            if (b1 || k1) begin
              done <= 1'b1; st <= S_IDLE;
              jump <= b1; npc <= b1 ? t1 : fall;
            end else begin
              st <= S_SECOND;
              if (rl) mem_issue <= 1'b1;
              else    int_issue <= 1'b1;
            end
          end
        end
        S_SECOND: if (a2) begin
          commit <= 1'b1; done <= 1'b1; st <= S_IDLE;
          jump <= b2; npc <= b2 ? t2 : fall;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_long_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_long |-> (mem_issue && !int_issue));
  assert_commit_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy || done));
  assert_err_nojump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (done && !jump));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_issue_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_issue || int_issue) |-> busy);
endmodule

// File: tb/pairword_dispatch_tb.sv
module pairword_dispatch_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] word = '0;
  logic [31:0] pc = '0;
  logic busy, mem_issue, int_issue, iss_long, commit, done, jump, err;
  logic [31:0] mem_bits, int_bits, npc;
  logic        mem_ack = 0, mem_br = 0, mem_kill = 0, int_ack = 0, int_br = 0, int_kill = 0;
  logic [31:0] mem_tgt = '0, int_tgt = '0;

  int checks = 0, errors = 0;
  bit exp_err = 0;
  bit poke = 0;

  always #4 clk = ~clk;

  pairword_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word), .pc(pc), .busy(busy),
    .mem_issue(mem_issue), .int_issue(int_issue), .iss_long(iss_long),
    .mem_bits(mem_bits), .int_bits(int_bits),
    .mem_ack(mem_ack), .mem_br(mem_br), .mem_tgt(mem_tgt), .mem_kill(mem_kill),
    .int_ack(int_ack), .int_br(int_br), .int_tgt(int_tgt), .int_kill(int_kill),
    .commit(commit), .done(done), .jump(jump), .npc(npc), .err(err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Stub units answer with the given values after the given latencies.
  task automatic run_one(input logic [63:0] w, input logic [31:0] p,
                         input bit mb, input logic [31:0] mt, input bit mk, input int ml,
                         input bit ib, input logic [31:0] it, input bit ik, input int il);
    int n_iss = 0, n_com = 0, mc = -1, ic = -1;
    int ord[2] = '{0, 0};
    bit got = 0, bits_ok = 1;
    logic [31:0] d_npc = '0;
    bit d_jump = 0;
    logic [1:0] f = {w[63], w[31]};
    int e_n, e_o0, e_o1, e_com;
    logic [31:0] e_npc;
    bit e_jump;
    mem_br = mb; mem_tgt = mt; mem_kill = mk;
    int_br = ib; int_tgt = it; int_kill = ik;
    @(negedge clk);
    word = w; pc = p; start = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      start = 1'b0; mem_ack = 1'b0; int_ack = 1'b0;
      if (poke && busy && k == 1) begin start = 1'b1; word = ~w; pc = p + 32'h100; end
      if (commit) n_com++;
      if (done) begin got = 1; d_npc = npc; d_jump = jump; break; end
      if (mem_issue || int_issue) begin
        if (n_iss < 2) ord[n_iss] = (mem_issue && int_issue) ? 3 : (mem_issue && iss_long) ? 4 : mem_issue ? 1 : 2;
        n_iss++;
        if (mem_bits != w[63:32] || int_bits != w[31:0]) bits_ok = 0;
      end
      if (mem_issue) mc = ml;
      if (int_issue) ic = il;
      if (mc == 0) begin mem_ack = 1'b1; mc = -1; end else if (mc > 0) mc--;
      if (ic == 0) begin int_ack = 1'b1; ic = -1; end else if (ic > 0) ic--;
    end
    start = 1'b0;
    // expected values from the requirements
    e_o1 = 0; e_jump = 0; e_npc = p + 32'd8;
    case (f)
      2'd0: begin
        e_n = 1; e_o0 = 3; e_com = 1;
        if (mb && ib) exp_err = 1;
        else if (mb) begin e_jump = 1; e_npc = mt; end
        else if (ib) begin e_jump = 1; e_npc = it; end
      end
      2'd3: begin
        e_n = 1; e_o0 = 4; e_com = 1;
        if (mb) begin e_jump = 1; e_npc = mt; end
      end
      default: begin
        bit b1 = (f == 2'd1) ? mb : ib;
        bit k1 = (f == 2'd1) ? mk : ik;
        bit b2 = (f == 2'd1) ? ib : mb;
        logic [31:0] t1 = (f == 2'd1) ? mt : it;
        logic [31:0] t2 = (f == 2'd1) ? it : mt;
        e_o0 = (f == 2'd1) ? 1 : 2;
        if (b1) begin e_n = 1; e_jump = 1; e_npc = t1; end
        else if (k1) e_n = 1;
        else begin
          e_n = 2; e_o1 = (f == 2'd1) ? 2 : 1;
          if (b2) begin e_jump = 1; e_npc = t2; end
        end
        e_com = e_n;
      end
    endcase
    chk(got, "R6 done seen", got, 1);
    chk(bits_ok, "R1 halves on issue buses", bits_ok, 1);
    chk(ord[0] == e_o0, (f == 2'd2) ? "R4 first issue unit" : (f == 2'd1) ? "R3 first issue unit" : (f == 2'd3) ? "R2 long issue" : "R7 paired issue", ord[0], e_o0);
    chk(n_iss == e_n, "R5 issue count", n_iss, e_n);
    if (e_n == 2) chk(ord[1] == e_o1, "R3 R4 second issue unit", ord[1], e_o1);
    chk(n_com == e_com, "R6 commit count", n_com, e_com);
    chk(d_jump == e_jump, e_jump ? "R5 R7 jump flag" : "R8 jump flag", d_jump, e_jump);
    chk(d_npc == e_npc, e_jump ? "R5 R7 next pc" : "R8 R9 fall-through pc", d_npc, e_npc);
    chk(err == exp_err, "R9 sticky error", err, exp_err);
  endtask

  function automatic logic [63:0] mk_word(input logic [1:0] f, input logic [63:0] r);
    logic [63:0] x = r;
    x[63] = f[1]; x[31] = f[0];
    return x;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !err && !done && !commit && !mem_issue && !int_issue, "R11 reset state",
        {busy, err, done, commit, mem_issue, int_issue}, 0);
    rst_n = 1'b1;
    // directed: no branches in each style (R8)
    for (int f = 0; f < 4; f++)
      run_one(mk_word(f[1:0], 64'h1234_5678_9abc_def0), 32'h1000, 0, 0, 0, 1, 0, 0, 0, 2);
    run_one(mk_word(2'd1, 64'h0f0f), 32'h2000, 1, 32'h40, 0, 0, 1, 32'h80, 0, 0); // R5 branch cancels second
    run_one(mk_word(2'd1, 64'h0f0f), 32'h2000, 0, 32'h40, 1, 2, 1, 32'h80, 0, 0); // R5 kill cancels second
    run_one(mk_word(2'd2, 64'h0f0f), 32'h2100, 0, 32'h44, 0, 0, 0, 32'h88, 1, 3); // R5 lower-first kill
    run_one(mk_word(2'd2, 64'h0f0f), 32'h2100, 1, 32'h44, 1, 1, 0, 32'h88, 0, 0); // R10 kill on second ignored
    run_one(mk_word(2'd0, 64'h55), 32'h3000, 0, 32'h50, 1, 3, 1, 32'h90, 1, 0);   // R7 int branch, R10 kill ignored
    run_one(mk_word(2'd0, 64'h55), 32'h3000, 1, 32'h50, 0, 0, 0, 32'h90, 0, 3);   // R7 mem branch
    run_one(mk_word(2'd3, 64'h77), 32'h3100, 1, 32'h60, 1, 2, 0, 0, 0, 0);        // R2 long branch
    poke = 1;
    run_one(mk_word(2'd1, 64'h99), 32'h3200, 0, 0, 0, 3, 0, 0, 0, 3);             // R10 start while busy
    poke = 0;
    run_one(mk_word(2'd0, 64'haa), 32'h4000, 1, 32'h70, 0, 1, 1, 32'h74, 0, 2);   // R9 dual branch
    run_one(mk_word(2'd1, 64'hbb), 32'h4100, 0, 0, 0, 0, 0, 0, 0, 0);             // R9 error stays
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [63:0] w = {$urandom, $urandom};
      run_one(w, $urandom & 32'hffff_fff8,
              ($urandom % 3) == 0, $urandom, ($urandom % 4) == 0, $urandom % 4,
              ($urandom % 3) == 0, $urandom, ($urandom % 4) == 0, $urandom % 4);
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!err && !busy, "R11 reset clears error", {err, busy}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule